// File: doc/BRIEF.md
# Lock Reservation Wake-Up Controller

This block sits between a bank of per-PE lock reservation registers and a programmable scheduler core. Every PE register holds a lock ID, a 4-bit priority nibble, a wants-reservation flag and a reserved flag. When a PE gives up its reservation on a lock, the block decides whether the scheduler core should be woken to pick the next holders of that lock. It only wakes the core when the wake-up can achieve something: some other PE is waiting on that lock, no other PE already holds a reservation on it, and the core is free.

On a wake-up the block writes a reserve command code and a set of argument words. The first word is a bitmask of the candidate PEs. The words after it carry the candidates' priority nibbles. Each PE's nibble sits in the slot given by its index, and unused slots are zero. The block then stays busy until the core reports its choice, which may name several PEs. The choice, limited to the candidates, goes back to the lock unit as a one-cycle write that sets those PEs' reserved flags. A clear event that cannot wake the core is dropped.

Top module: `rsv_wake_ctrl`

## Requirements
- R1: After reset `cmd_valid`, `res_valid` and `busy` are 0, and `cmd_code` and `cmd_args` are all zero.
- R2: A clear event is registered on the rising edge that samples `clr_vec`. It is judged against the lock ID that the clearing PE's register held at that edge. If it qualifies, `cmd_valid` is 1 for exactly one cycle, starting at the next rising edge.
- R3: No command is issued when another PE's register with the same lock ID has its reserved flag set. Reserved flags on other lock IDs have no effect.
- R4: No command is issued unless at least one other PE's register with the same lock ID has its wants-reservation flag set.
- R5: No command is issued while `core_idle` is 0 or `busy` is 1. An event rejected for any reason is discarded, not retried.
- R6: The clearing PE's own flags never take part in the decision, and that PE is never a candidate.
- R7: Argument word 0 (`cmd_args[31:0]`) holds the candidate mask: bit i is set when PE i has the cleared lock ID and wants a reservation. The bits above the PE count are zero.
- R8: Argument words 1 and 2 (`cmd_args[95:32]`) hold PE i's nibble at bits [4i+3:4i] of that 64-bit field when PE i is a candidate, and zero otherwise. `cmd_code` is 8'hA5 on a command.
- R9: `busy` rises together with `cmd_valid` and stays set until `core_done`. On the edge that samples `core_done`, `busy` falls and `res_valid` pulses for one cycle. `res_mask` is then `core_pick` ANDed with the candidate mask, and `res_lock` is the cleared lock ID.
- R10: `core_done` while `busy` is 0 is ignored: `res_valid` stays 0.
- R11: When several PEs clear in the same cycle, the lowest PE index is judged first. Each further event is judged one cycle later, in index order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_lock | input | 96 | Lock ID of each PE register, 8 bits per PE, PE 0 lowest |
| slot_info | input | 48 | Priority nibble of each PE register |
| slot_want | input | 12 | Wants-reservation flag per PE |
| slot_held | input | 12 | Reserved flag per PE |
| clr_vec | input | 12 | One bit per PE: clear-reservation event this cycle |
| core_idle | input | 1 | Scheduler core is idle |
| core_done | input | 1 | Scheduler core reports its choice |
| core_pick | input | 12 | PEs chosen by the core |
| cmd_valid | output | 1 | One-cycle command strobe to the core |
| cmd_code | output | 8 | Command code |
| cmd_args | output | 96 | Argument words 0..2, word 0 lowest |
| busy | output | 1 | Waiting for the core's answer |
| res_valid | output | 1 | One-cycle result write toward the lock unit |
| res_mask | output | 12 | PEs whose reserved flag is to be set |
| res_lock | output | 8 | Lock ID the result applies to |

## Verification
Two clear events can arrive in the same cycle, and the ordering is tested in two ways. In the first case the lower PE's event fails its conditions and the higher PE's event qualifies: the command must come one cycle later than usual and carry only the higher PE's candidates. In the second case both events qualify. The lower PE's command must come first, and the higher PE's event must then be dropped because the block is busy. No command may follow, even after the core answers. A table of register configurations also covers held flags, missing wanters, an idle core and self-exclusion, and the candidate mask and nibble placement are rebuilt independently in the bench.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
   localparam int unsigned RSV_CMD_W    = 8;
   localparam logic [7:0]  RSV_CMD_CODE = 8'hA5;

   // mask word plus enough words to hold one nibble slot per PE
   function automatic int unsigned rsv_arg_words(input int unsigned n_pe,
                                                 input int unsigned info_w,
                                                 input int unsigned word_w);
      return 1 + (n_pe * info_w + word_w - 1) / word_w;
   endfunction
endpackage

// File: rtl/rsv_clear_queue.sv
module rsv_clear_queue #(
   parameter int unsigned NUM_PE = 12,
   parameter int unsigned LOCK_W = 8,
   localparam int unsigned IDX_W = $clog2(NUM_PE)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_PE-1:0]        clr_vec,
   input  logic [NUM_PE*LOCK_W-1:0] slot_lock,
   output logic                     sel_valid,
   output logic [IDX_W-1:0]         sel_idx,
   output logic [LOCK_W-1:0]        sel_lock
);
   logic [NUM_PE-1:0] pend_q;
   logic [LOCK_W-1:0] plock_q [NUM_PE];

   // lowest pending index wins
   always_comb begin
      sel_valid = 1'b0;
      sel_idx   = '0;
      sel_lock  = '0;
      for (int i = NUM_PE - 1; i >= 0; i--) begin
         if (pend_q[i]) begin
            sel_valid = 1'b1;
            sel_idx   = IDX_W'(i);
            sel_lock  = plock_q[i];
         end
      end
   end

   for (genvar g = 0; g < NUM_PE; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_q[g]  <= 1'b0;
            plock_q[g] <= '0;
         end else if (clr_vec[g]) begin
            pend_q[g]  <= 1'b1;
            plock_q[g] <= slot_lock[g*LOCK_W +: LOCK_W];
         end else if (sel_valid && sel_idx == IDX_W'(g)) begin
            pend_q[g]  <= 1'b0;
         end
      end
   end

   AST_ONE_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_valid && !(|clr_vec)) |=> ($countones(pend_q) == $countones($past(pend_q)) - 1)) // R11
      else $error("pending set did not shrink by one");
endmodule

// File: rtl/rsv_trigger_eval.sv
module rsv_trigger_eval #(
   parameter int unsigned NUM_PE = 12,
   parameter int unsigned LOCK_W = 8,
   localparam int unsigned IDX_W = $clog2(NUM_PE)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sel_valid,
   input  logic [IDX_W-1:0]         sel_idx,
   input  logic [LOCK_W-1:0]        sel_lock,
   input  logic [NUM_PE*LOCK_W-1:0] slot_lock,
   input  logic [NUM_PE-1:0]        slot_want,
   input  logic [NUM_PE-1:0]        slot_held,
   input  logic                     ready,
   output logic                     fire,
   output logic [NUM_PE-1:0]        cand
);
   logic [NUM_PE-1:0] same;

   for (genvar g = 0; g < NUM_PE; g++) begin : g_cmp
      assign same[g] = (slot_lock[g*LOCK_W +: LOCK_W] == sel_lock) &&
                       (sel_idx != IDX_W'(g));
   end

   assign cand = same & slot_want;
   assign fire = sel_valid && ready && (|cand) && !(|(same & slot_held));

   AST_NO_SELF: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> !cand[sel_idx]) // R6
      else $error("clearing PE listed as candidate");
endmodule

// File: rtl/rsv_arg_pack.sv
module rsv_arg_pack #(
   parameter int unsigned NUM_PE = 12,
   parameter int unsigned INFO_W = 4,
   parameter int unsigned WORD_W = 32,
   parameter int unsigned ARG_N  = 3,
   localparam int unsigned PACK_W = (ARG_N - 1) * WORD_W,
   localparam int unsigned USED_W = NUM_PE * INFO_W
) (
   input  logic [NUM_PE-1:0]        cand,
   input  logic [NUM_PE*INFO_W-1:0] slot_info,
   output logic [ARG_N*WORD_W-1:0]  args
);
   logic [PACK_W-1:0] nib;

   for (genvar g = 0; g < NUM_PE; g++) begin : g_nib
      assign nib[g*INFO_W +: INFO_W] = cand[g] ? slot_info[g*INFO_W +: INFO_W] : '0;
   end
   if (PACK_W > USED_W) begin : g_nib_pad
      assign nib[PACK_W-1:USED_W] = '0;
   end

   assign args[NUM_PE-1:0] = cand;
   if (WORD_W > NUM_PE) begin : g_mask_pad
      assign args[WORD_W-1:NUM_PE] = '0;
   end
   assign args[ARG_N*WORD_W-1:WORD_W] = nib;
endmodule

// File: rtl/rsv_wake_ctrl.sv
module rsv_wake_ctrl
   import rsv_pkg::*;
#(
   parameter int unsigned NUM_PE = 12,
   parameter int unsigned LOCK_W = 8,
   parameter int unsigned INFO_W = 4,
   parameter int unsigned WORD_W = 32,
   parameter logic [RSV_CMD_W-1:0] CMD_CODE = RSV_CMD_CODE,
   localparam int unsigned ARG_N = rsv_arg_words(NUM_PE, INFO_W, WORD_W),
   localparam int unsigned IDX_W = $clog2(NUM_PE)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_PE*LOCK_W-1:0] slot_lock,
   input  logic [NUM_PE*INFO_W-1:0] slot_info,
   input  logic [NUM_PE-1:0]        slot_want,
   input  logic [NUM_PE-1:0]        slot_held,
   input  logic [NUM_PE-1:0]        clr_vec,
   input  logic                     core_idle,
   input  logic                     core_done,
   input  logic [NUM_PE-1:0]        core_pick,
   output logic                     cmd_valid,
   output logic [RSV_CMD_W-1:0]     cmd_code,
   output logic [ARG_N*WORD_W-1:0]  cmd_args,
   output logic                     busy,
   output logic                     res_valid,
   output logic [NUM_PE-1:0]        res_mask,
   output logic [LOCK_W-1:0]        res_lock
);
   if (NUM_PE > WORD_W) begin : g_chk_mask
      $error("candidate mask does not fit in one argument word");
   end
   if (NUM_PE < 2) begin : g_chk_pe
      $error("at least two PEs are required");
   end

   logic                    sel_valid;
   logic [IDX_W-1:0]        sel_idx;
   logic [LOCK_W-1:0]       sel_lock;
   logic                    fire;
   logic [NUM_PE-1:0]       cand;
   logic [ARG_N*WORD_W-1:0] packed_args;
   logic [NUM_PE-1:0]       cand_q;
   logic [LOCK_W-1:0]       lock_q;

   rsv_clear_queue #(.NUM_PE(NUM_PE), .LOCK_W(LOCK_W)) i_queue (
      .clk, .rst_n, .clr_vec, .slot_lock,
      .sel_valid, .sel_idx, .sel_lock
   );

   rsv_trigger_eval #(.NUM_PE(NUM_PE), .LOCK_W(LOCK_W)) i_eval (
      .clk, .rst_n, .sel_valid, .sel_idx, .sel_lock,
      .slot_lock, .slot_want, .slot_held,
      .ready(core_idle && !busy),
      .fire, .cand
   );

   rsv_arg_pack #(.NUM_PE(NUM_PE), .INFO_W(INFO_W), .WORD_W(WORD_W), .ARG_N(ARG_N)) i_pack (
      .cand, .slot_info, .args(packed_args)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_valid <= 1'b0;
         cmd_code  <= '0;
         cmd_args  <= '0;
         busy      <= 1'b0;
         cand_q    <= '0;
         lock_q    <= '0;
         res_valid <= 1'b0;
         res_mask  <= '0;
         res_lock  <= '0;
      end else begin
         cmd_valid <= fire;
         res_valid <= 1'b0;
         if (fire) begin
            cmd_code <= CMD_CODE;
            cmd_args <= packed_args;
            busy     <= 1'b1;
            cand_q   <= cand;
            lock_q   <= sel_lock;
         end else if (busy && core_done) begin
            busy      <= 1'b0;
            res_valid <= 1'b1;
            res_mask  <= core_pick & cand_q;
            res_lock  <= lock_q;
         end
      end
   end

   AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid) // R2
      else $error("command strobe longer than one cycle");
   AST_CMD_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> ($past(core_idle) && !$past(busy))) // R5
      else $error("command issued to a busy core");
   AST_BUSY_WITH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_valid) |-> busy) // R9
      else $error("busy not raised with command");
   AST_RES_IN_CAND: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> ((res_mask & ~cand_q) == '0)) // R9
      else $error("result names a non-candidate");
   AST_RES_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> ($past(busy) && !busy)) // R10
      else $error("result without an outstanding command");
endmodule

// File: tb/test_rsv_wake_ctrl.sv
`timescale 1ns/1ps
module test_rsv_wake_ctrl;
   localparam int NPE = 12;
   localparam logic [7:0] LK_A = 8'h2A;
   localparam logic [7:0] LK_B = 8'h3C;
   localparam logic [7:0] LK_O = 8'h11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NPE*8-1:0] slot_lock = '0;
   logic [NPE*4-1:0] slot_info = '0;
   logic [NPE-1:0]   slot_want = '0, slot_held = '0, clr_vec = '0, core_pick = '0;
   logic core_idle = 1'b1, core_done = 1'b0;
   logic cmd_valid, busy, res_valid;
   logic [7:0] cmd_code, res_lock;
   logic [95:0] cmd_args;
   logic [NPE-1:0] res_mask;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   rsv_wake_ctrl i_rsv_wake_ctrl (
      .clk, .rst_n, .slot_lock, .slot_info, .slot_want, .slot_held,
      .clr_vec, .core_idle, .core_done, .core_pick,
      .cmd_valid, .cmd_code, .cmd_args, .busy,
      .res_valid, .res_mask, .res_lock
   );

   // vector: {clearing PE, same-lock mask, want mask, held mask, core idle}
   localparam int NV = 8;
   localparam logic [40:0] VEC [NV] = '{
      {4'd0,  12'hFFF, 12'h0F0, 12'h000, 1'b1},  // R4 R7 fire
      {4'd3,  12'hFFF, 12'h008, 12'h000, 1'b1},  // R6 only self wants
      {4'd3,  12'hFFF, 12'h00F, 12'h008, 1'b1},  // R6 self held ignored
      {4'd5,  12'h0FF, 12'hF00, 12'h000, 1'b1},  // R4 wanters on other lock
      {4'd5,  12'hFFF, 12'hF00, 12'h001, 1'b1},  // R3 other holds lock
      {4'd11, 12'hFFF, 12'h7FF, 12'h000, 1'b0},  // R5 core not idle
      {4'd2,  12'h00F, 12'hFFF, 12'hF00, 1'b1},  // R3 held on other lock
      {4'd7,  12'hFFF, 12'hFFF, 12'h000, 1'b1}   // R8 all nibbles
   };

   function automatic logic [3:0] info_of(input int i);
      return 4'((i * 7 + 3) % 16);
   endfunction

   function automatic string tag_of(input int k);
      case (k)
         0: return "R4";
         1, 2: return "R6";
         3: return "R4";
         4, 6: return "R3";
         5: return "R5";
         default: return "R8";
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [95:0] act, input logic [95:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic set_locks(input logic [7:0] lk [NPE]);
      for (int i = 0; i < NPE; i++) slot_lock[i*8 +: 8] = lk[i];
   endtask

   task automatic answer(input logic [NPE-1:0] pick);
      @(negedge clk);
      core_done = 1'b1;
      core_pick = pick;
      @(negedge clk);
      core_done = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] lk [NPE];
      for (int i = 0; i < NPE; i++) slot_info[i*4 +: 4] = info_of(i);
      repeat (3) @(negedge clk);
      // R1 reset values
      chk(cmd_valid == 1'b0, "R1", "cmd_valid", 96'(cmd_valid), 96'd0);
      chk(res_valid == 1'b0, "R1", "res_valid", 96'(res_valid), 96'd0);
      chk(busy == 1'b0, "R1", "busy", 96'(busy), 96'd0);
      chk(cmd_args == '0, "R1", "cmd_args", cmd_args, 96'd0);
      chk(cmd_code == '0, "R1", "cmd_code", 96'(cmd_code), 96'd0);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         int pe;
         logic [11:0] same, want, held, self, cand, other_held;
         logic [63:0] enib;
         logic efire;
         pe   = int'(VEC[k][40:37]);
         same = VEC[k][36:25];
         want = VEC[k][24:13];
         held = VEC[k][12:1];
         self = 12'(1) << pe;
         same = same | self;
         cand = same & want & ~self;
         other_held = same & held & ~self;
         efire = (cand != '0) && (other_held == '0) && VEC[k][0];
         enib = '0;
         for (int i = 0; i < NPE; i++) if (cand[i]) enib[i*4 +: 4] = info_of(i);

         @(negedge clk);
         for (int i = 0; i < NPE; i++) lk[i] = same[i] ? LK_A : LK_O;
         set_locks(lk);
         slot_want = want;
         slot_held = held;
         core_idle = VEC[k][0];
         clr_vec = self;
         @(negedge clk);
         clr_vec = '0;
         @(negedge clk);
         chk(cmd_valid == efire, tag_of(k), "cmd_valid", 96'(cmd_valid), 96'(efire));
         if (efire) begin
            chk(cmd_args[31:0] == 32'(cand), "R7", "mask word", 96'(cmd_args[31:0]), 96'(cand));
            chk(cmd_args[95:32] == enib, "R8", "nibble words", 96'(cmd_args[95:32]), 96'(enib));
            chk(cmd_code == 8'hA5, "R8", "cmd_code", 96'(cmd_code), 96'hA5);
            chk(busy == 1'b1, "R9", "busy", 96'(busy), 96'd1);
            @(negedge clk);
            chk(cmd_valid == 1'b0, "R2", "strobe width", 96'(cmd_valid), 96'd0);
            core_done = 1'b1;
            core_pick = 12'hFFF;
            @(negedge clk);
            core_done = 1'b0;
            chk(res_valid == 1'b1, "R9", "res_valid", 96'(res_valid), 96'd1);
            chk(res_mask == cand, "R9", "res_mask", 96'(res_mask), 96'(cand));
            chk(res_lock == LK_A, "R9", "res_lock", 96'(res_lock), 96'(LK_A));
            chk(busy == 1'b0, "R9", "busy clear", 96'(busy), 96'd0);
         end
      end

      // R10: answer with nothing outstanding
      core_idle = 1'b1;
      answer(12'h00F);
      chk(res_valid == 1'b0, "R10", "stray done", 96'(res_valid), 96'd0);

      // R11 case 1: PE1 fails (no wanter on A), PE4 qualifies one cycle later
      @(negedge clk);
      for (int i = 0; i < NPE; i++) lk[i] = LK_O;
      lk[0] = LK_A; lk[1] = LK_A; lk[4] = LK_B; lk[6] = LK_B;
      set_locks(lk);
      slot_held = '0;
      slot_want = 12'h040;
      clr_vec = 12'h012;
      @(negedge clk);
      clr_vec = '0;
      @(negedge clk);
      chk(cmd_valid == 1'b0, "R11", "lower PE judged first", 96'(cmd_valid), 96'd0);
      @(negedge clk);
      chk(cmd_valid == 1'b1, "R11", "higher PE one cycle later", 96'(cmd_valid), 96'd1);
      chk(cmd_args[31:0] == 32'h40, "R11", "mask of PE4 lock", 96'(cmd_args[31:0]), 96'h40);
      answer(12'h040);
      chk(res_lock == LK_B, "R11", "res_lock", 96'(res_lock), 96'(LK_B));

      // R11 case 2: both qualify; PE1 first, PE4 dropped while busy (R5)
      @(negedge clk);
      slot_want = 12'h041;
      clr_vec = 12'h012;
      @(negedge clk);
      clr_vec = '0;
      @(negedge clk);
      chk(cmd_valid == 1'b1, "R11", "lower PE fires", 96'(cmd_valid), 96'd1);
      chk(cmd_args[31:0] == 32'h1, "R11", "mask of PE1 lock", 96'(cmd_args[31:0]), 96'h1);
      @(negedge clk);
      chk(cmd_valid == 1'b0, "R5", "second event dropped while busy", 96'(cmd_valid), 96'd0);
      answer(12'hFFF);
      chk(res_mask == 12'h001, "R9", "pick masked to candidates", 96'(res_mask), 96'h1);
      chk(res_lock == LK_A, "R9", "res_lock", 96'(res_lock), 96'(LK_A));
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         chk(cmd_valid == 1'b0, "R5", "dropped event not retried", 96'(cmd_valid), 96'd0);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule